// File: doc/BRIEF.md
# Two-wire register block transfer sequencer

This block runs whole register-block reads and writes on a two-wire serial bus. It does so by issuing byte-level operations to a separate byte engine, which handles the bit timing. A request carries five things: a direction, a legacy flag, a 16-bit device descriptor, an offset and a byte count. Bits 15:8 of the descriptor give the number of offset bytes. Bits 7:1 give the 7-bit device address.

In normal mode the block first sends the device address with the write flag. It then sends the offset bytes, low byte first, and leaves an idle gap after each one. For a read it next sends a repeated START with the device address and the read flag, then clocks the data in. For a write it sends the data bytes instead. In legacy mode the offset itself goes in the address byte, and the data phase follows at once.

Read bytes leave on a valid/ready stream, and write bytes arrive on another. Each request ends with a one-cycle completion pulse and an error code. The bus is always released with a STOP, except when a request is rejected before any bus activity.

Top module: `twc_blkxfer`

## Requirements
- R1: In normal mode the first engine operation is a START-and-write (code 1) whose byte is {req_desc[7:1], 0}. The offset byte count comes from req_desc[15:8]. The read-direction address byte is {req_desc[7:1], 1}, so bit 0 is 1 for read and 0 for write.
- R2: A normal-mode request whose req_desc[15:8] exceeds MAX_OFS (default 2) issues no engine operation. It completes with err_code 1.
- R3: Offset bytes go out as plain writes (code 2), lowest byte first. After each offset byte is acknowledged, at least GAP_CYCLES clock cycles pass before the next operation is offered.
- R4: A normal read issues, in order: START-and-write with the write address, the offset bytes, START-and-write with the read address, the data reads, and a STOP (code 5).
- R5: In legacy mode the first operation is START-and-write with byte {req_offset[6:0], rw}, where rw is 1 for a read. No offset bytes and no repeated START follow; the data phase comes directly.
- R6: Every data read except the last is a read-with-ACK (code 3). The last one is a read-with-NACK (code 4), followed by STOP. The bytes appear on rd_data in the order they were read.
- R7: A NACK on any address byte or offset byte is followed by STOP only. The request completes with err_code 2.
- R8: Write data bytes are taken from the write stream and sent as code 2 writes. A NACK on one of them is followed by STOP and err_code 3. If every byte is acknowledged, STOP follows and err_code is 0.
- R9: A request with req_len of 0 issues only a STOP and completes with err_code 0.
- R10: eng_op and eng_byte stay stable while eng_valid is high and eng_ready is low. No new operation is offered until eng_done answers the previous one.
- R11: done is high for exactly one cycle per request. req_ready is high only when the block is idle, which includes the state out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request accepted on valid and ready |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_legacy | input | 1 | Offset is placed inside the address byte |
| req_desc | input | 16 | [15:8] offset byte count, [7:1] device address |
| req_offset | input | 8*MAX_OFS | Register offset |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Block takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| eng_valid | output | 1 | Byte operation offered to the engine |
| eng_ready | input | 1 | Engine accepts the operation |
| eng_op | output | 3 | 1 START+write, 2 write, 3 read+ACK, 4 read+NACK, 5 STOP |
| eng_byte | output | 8 | Byte to send (0 for reads and STOP) |
| eng_done | input | 1 | Engine finished the accepted operation |
| eng_nack | input | 1 | With eng_done: the written byte was not acknowledged |
| eng_rdata | input | 8 | With eng_done: byte read from the bus |
| done | output | 1 | Request complete (one cycle) |
| err_code | output | 2 | 0 ok, 1 offset size too large, 2 address/offset NACK, 3 data NACK |

## Verification
The assertions take several things for granted about the engine. It raises eng_done only for an operation it has accepted, never in the same cycle as the acceptance, and for one cycle only. It also keeps eng_nack and eng_rdata meaningful in that cycle. The bench engine model behaves exactly this way. It samples an offer at one falling edge, answers after a random latency of zero to two further cycles, and varies eng_ready from cycle to cycle. The random stimulus keeps offset counts between 0 and 3 and lengths between 0 and 8. It places NACKs only on write-type operations, so the expected sequence stays well defined.

// File: rtl/twc_pkg.sv
package twc_pkg;

    // Byte-engine operation codes; the engine decodes these values.
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_START_WR = 3'd1,
        OP_WR       = 3'd2,
        OP_RD_ACK   = 3'd3,
        OP_RD_NACK  = 3'd4,
        OP_STOP     = 3'd5
    } twc_op_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SIZE = 2'd1,
        ERR_ADDR = 2'd2,
        ERR_DATA = 2'd3
    } twc_err_e;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_HDR    = 4'd1,
        S_OFS    = 4'd2,
        S_GAP    = 4'd3,
        S_RHDR   = 4'd4,
        S_RD     = 4'd5,
        S_RDOUT  = 4'd6,
        S_WFETCH = 4'd7,
        S_WR     = 4'd8,
        S_STOP   = 4'd9,
        S_DONE   = 4'd10
    } twc_state_e;

endpackage

// File: rtl/twc_gap.sv
module twc_gap #(
    parameter int GAP_CYCLES = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = (GAP_CYCLES < 1) ? 1 : $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(GAP_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/twc_lenctr.sv
module twc_lenctr #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LEN_W'(1));

endmodule

// File: rtl/twc_hdr.sv
module twc_hdr #(
    parameter int OFS_W = 16,
    parameter int IDX_W = 2
) (
    input  logic             legacy,
    input  logic [6:0]       dev_addr,
    input  logic [OFS_W-1:0] ofs,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       addr_wr,
    output logic [7:0]       addr_rd,
    output logic [7:0]       ofs_byte
);
    // Legacy mode folds the low offset bits into the address byte.
    always_comb begin
        if (legacy) begin
            addr_wr = {ofs[6:0], 1'b0};
            addr_rd = {ofs[6:0], 1'b1};
        end else begin
            addr_wr = {dev_addr, 1'b0};
            addr_rd = {dev_addr, 1'b1};
        end
        ofs_byte = 8'(ofs >> {idx, 3'b000});
    end

endmodule

// File: rtl/twc_blkxfer.sv
module twc_blkxfer
    import twc_pkg::*;
#(
    parameter  int LEN_W      = 16,
    parameter  int MAX_OFS    = 2,
    parameter  int GAP_CYCLES = 6000,
    localparam int OFS_W      = 8 * MAX_OFS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_legacy,
    input  logic [15:0]      req_desc,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             eng_valid,
    input  logic             eng_ready,
    output logic [2:0]       eng_op,
    output logic [7:0]       eng_byte,
    input  logic             eng_done,
    input  logic             eng_nack,
    input  logic [7:0]       eng_rdata,
    output logic             done,
    output logic [1:0]       err_code
);
    localparam int IDX_W = $clog2(MAX_OFS + 1);

    typedef struct packed {
        twc_state_e       st;
        logic             sent;
        logic [IDX_W-1:0] idx;
        twc_err_e         err;
        logic             wr;
        logic             leg;
        logic [6:0]       dev;
        logic [7:0]       nofs;
        logic [OFS_W-1:0] ofs;
        logic [7:0]       data;
    } ctl_t;

    ctl_t q, n;

    logic       cnt_load, cnt_dec, cnt_last;
    logic       gap_start, gap_busy;
    logic       fin;
    logic [7:0] addr_wr, addr_rd, ofs_byte;

    twc_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (gap_start),
        .busy  (gap_busy)
    );

    twc_lenctr #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (req_len),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    twc_hdr #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_hdr (
        .legacy   (q.leg),
        .dev_addr (q.dev),
        .ofs      (q.ofs),
        .idx      (q.idx),
        .addr_wr  (addr_wr),
        .addr_rd  (addr_rd),
        .ofs_byte (ofs_byte)
    );

    always_comb begin
        n         = q;
        fin       = q.sent & eng_done;
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        eng_valid = 1'b0;
        eng_op    = OP_NONE;
        eng_byte  = 8'h00;
        done      = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        gap_start = 1'b0;

        case (q.st)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    n.wr     = req_write;
                    n.leg    = req_legacy;
                    n.dev    = req_desc[7:1];
                    n.nofs   = req_desc[15:8];
                    n.ofs    = req_offset;
                    n.idx    = '0;
                    n.err    = ERR_NONE;
                    n.sent   = 1'b0;
                    cnt_load = 1'b1;
                    if (!req_legacy && (req_desc[15:8] > 8'(MAX_OFS))) begin
                        n.err = ERR_SIZE;
                        n.st  = S_DONE;
                    end else if (req_len == '0) begin
                        n.st = S_STOP;
                    end else begin
                        n.st = S_HDR;
                    end
                end
            end
            S_HDR: begin
                eng_valid = !q.sent;
                eng_op    = OP_START_WR;
                eng_byte  = (q.leg && !q.wr) ? addr_rd : addr_wr;
                if (fin) begin
                    if (eng_nack) begin
                        n.err = ERR_ADDR;
                        n.st  = S_STOP;
                    end else if (q.leg) begin
                        n.st = q.wr ? S_WFETCH : S_RD;
                    end else if (q.nofs != 8'd0) begin
                        n.st = S_OFS;
                    end else begin
                        n.st = q.wr ? S_WFETCH : S_RHDR;
                    end
                end
            end
            S_OFS: begin
                eng_valid = !q.sent;
                eng_op    = OP_WR;
                eng_byte  = ofs_byte;
                if (fin) begin
                    if (eng_nack) begin
                        n.err = ERR_ADDR;
                        n.st  = S_STOP;
                    end else begin
                        n.idx     = q.idx + 1'b1;
                        gap_start = 1'b1;
                        n.st      = S_GAP;
                    end
                end
            end
            S_GAP: begin
                if (!gap_busy) begin
                    if (8'(q.idx) == q.nofs) n.st = q.wr ? S_WFETCH : S_RHDR;
                    else                     n.st = S_OFS;
                end
            end
            S_RHDR: begin
                eng_valid = !q.sent;
                eng_op    = OP_START_WR;
                eng_byte  = addr_rd;
                if (fin) begin
                    if (eng_nack) begin
                        n.err = ERR_ADDR;
                        n.st  = S_STOP;
                    end else begin
                        n.st = S_RD;
                    end
                end
            end
            S_RD: begin
                eng_valid = !q.sent;
                eng_op    = cnt_last ? OP_RD_NACK : OP_RD_ACK;
                if (fin) begin
                    n.data = eng_rdata;
                    n.st   = S_RDOUT;
                end
            end
            S_RDOUT: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    cnt_dec = 1'b1;
                    n.st    = cnt_last ? S_STOP : S_RD;
                end
            end
            S_WFETCH: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    n.data = wr_data;
                    n.st   = S_WR;
                end
            end
            S_WR: begin
                eng_valid = !q.sent;
                eng_op    = OP_WR;
                eng_byte  = q.data;
                if (fin) begin
                    if (eng_nack) begin
                        n.err = ERR_DATA;
                        n.st  = S_STOP;
                    end else begin
                        cnt_dec = 1'b1;
                        n.st    = cnt_last ? S_STOP : S_WFETCH;
                    end
                end
            end
            S_STOP: begin
                eng_valid = !q.sent;
                eng_op    = OP_STOP;
                if (fin) n.st = S_DONE;
            end
            S_DONE: begin
                done = 1'b1;
                n.st = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase

        if (eng_valid && eng_ready) n.sent = 1'b1;
        if (fin)                    n.sent = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rd_data  = q.data;
    assign err_code = q.err;

    // Checker state: whether the last operation the engine accepted was a STOP.
    logic last_stop_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_stop_q <= 1'b0;
        else if (eng_valid && eng_ready) last_stop_q <= (eng_op == OP_STOP);
        else if (req_valid && req_ready) last_stop_q <= 1'b0;
    end

    // R10
    eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid && !eng_ready |=> eng_valid && $stable(eng_op) && $stable(eng_byte));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R3
    gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_busy |-> !eng_valid);

    // R8
    stop_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && (err_code != ERR_SIZE) |-> last_stop_q);

    // R2
    size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_legacy && (req_desc[15:8] > 8'(MAX_OFS))
        |=> done && (err_code == ERR_SIZE));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

endmodule

// File: tb/sim_twc_blkxfer.sv
module sim_twc_blkxfer;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_legacy;
    logic [15:0] req_desc, req_offset, req_len;
    logic        wr_valid, wr_ready;
    logic [7:0]  wr_data;
    logic        rd_valid, rd_ready;
    logic [7:0]  rd_data;
    logic        eng_valid, eng_ready;
    logic [2:0]  eng_op;
    logic [7:0]  eng_byte;
    logic        eng_done, eng_nack;
    logic [7:0]  eng_rdata;
    logic        done;
    logic [1:0]  err_code;

    twc_blkxfer #(.LEN_W(16), .MAX_OFS(2), .GAP_CYCLES(GAP)) u0 (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int got_ops[64], acc_cyc[64], done_cyc[64], got_n;
    int got_rd[64], got_rn;
    int exp_ops[64], exp_n, exp_rd[64], exp_rn, exp_err;
    bit [7:0] wdat[64];
    int widx, nack_at_g, rbase, hold_viol;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int rpat(int k);
        return (k * 53 + rbase) & 255;
    endfunction

    task automatic add(int op, int b);
        if (exp_n < 64) exp_ops[exp_n] = op * 256 + (b & 255);
        exp_n++;
    endtask

    // Expected engine operation list, error code and read bytes.
    task automatic build_exp(bit wr, bit leg, int desc, int ofs, int len, int nk);
        int nofs;
        nofs = (desc >> 8) & 255;
        exp_n = 0; exp_rn = 0; exp_err = 0;
        if (!leg && nofs > 2) begin exp_err = 1; return; end
        if (len == 0) begin add(5, 0); return; end
        add(1, leg ? (((ofs & 127) << 1) | (wr ? 0 : 1)) : (desc & 254));
        if (exp_n - 1 == nk) begin add(5, 0); exp_err = 2; return; end
        if (!leg) begin
            for (int i = 0; i < nofs; i++) begin
                add(2, (ofs >> (8 * i)) & 255);
                if (exp_n - 1 == nk) begin add(5, 0); exp_err = 2; return; end
            end
            if (!wr) begin
                add(1, (desc & 254) | 1);
                if (exp_n - 1 == nk) begin add(5, 0); exp_err = 2; return; end
            end
        end
        for (int i = 0; i < len; i++) begin
            if (wr) begin
                add(2, wdat[i]);
                if (exp_n - 1 == nk) begin add(5, 0); exp_err = 3; return; end
            end else begin
                exp_rd[exp_rn] = rpat(exp_n);
                exp_rn++;
                add((i == len - 1) ? 4 : 3, 0);
            end
        end
        add(5, 0);
    endtask

    // Engine, read consumer and write source, all acting on falling edges.
    initial begin
        bit pend = 0, pnack = 0, take = 0, hold_p = 0, rdy;
        int lat = 0, pidx = 0, hop = 0, hbyte = 0;
        bit [7:0] prd = 0;
        forever begin
            @(negedge clk);
            cyc++;
            eng_done = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    eng_done = 1'b1; eng_nack = pnack; eng_rdata = prd;
                    if (pidx < 64) done_cyc[pidx] = cyc;
                    pend = 0;
                end else lat--;
            end
            if (hold_p) begin
                if (!eng_valid || int'(eng_op) != hop || int'(eng_byte) != hbyte) hold_viol++;
                hold_p = 0;
            end
            rdy = ($urandom % 3) != 0;
            eng_ready = rdy;
            if (eng_valid && rdy) begin
                pidx = got_n;
                if (got_n < 64) begin
                    got_ops[got_n] = int'(eng_op) * 256 + int'(eng_byte);
                    acc_cyc[got_n] = cyc;
                end
                got_n++;
                pend  = 1;
                lat   = $urandom % 3;
                pnack = (pidx == nack_at_g) && (eng_op == 3'd1 || eng_op == 3'd2);
                prd   = 8'(rpat(pidx));
            end else if (eng_valid) begin
                hold_p = 1; hop = int'(eng_op); hbyte = int'(eng_byte);
            end
            rdy = ($urandom % 4) != 0;
            rd_ready = rdy;
            if (rd_valid && rdy && got_rn < 64) begin
                got_rd[got_rn] = int'(rd_data);
                got_rn++;
            end
            if (take) begin widx++; take = 0; end
            wr_valid = (($urandom % 4) != 0) && widx < 64;
            wr_data  = wdat[widx & 63];
            if (wr_valid && wr_ready) take = 1;
        end
    end

    task automatic run(string tag, bit wr, bit leg, int desc, int ofs, int len, int nk);
        int wd, err_seen;
        for (int i = 0; i < 64; i++) wdat[i] = 8'($urandom);
        rbase = $urandom & 255;
        build_exp(wr, leg, desc, ofs, len, nk);
        got_n = 0; got_rn = 0; widx = 0; hold_viol = 0; nack_at_g = nk;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_legacy = leg;
        req_desc = 16'(desc); req_offset = 16'(ofs); req_len = 16'(len);
        wd = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            wd++;
        end while (!done && wd < 5000);
        if (wd >= 5000) begin chk(0, tag, "completion timeout", wd, 0); return; end
        err_seen = int'(err_code);
        @(negedge clk);
        chk(!done && req_ready, "R11", "idle after done pulse", int'({done, req_ready}), 1);
        chk(got_n == exp_n, tag, "operation count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 64; i++)
            chk(got_ops[i] == exp_ops[i], tag, "operation", got_ops[i], exp_ops[i]);
        chk(err_seen == exp_err, tag, "error code", err_seen, exp_err);
        if (!wr) begin
            chk(got_rn == exp_rn, tag, "read byte count", got_rn, exp_rn);
            for (int i = 0; i < exp_rn && i < got_rn; i++)
                chk(got_rd[i] == exp_rd[i], "R6", "read byte", got_rd[i], exp_rd[i]);
        end
        chk(hold_viol == 0, "R10", "offer held while stalled", hold_viol, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog: actual %0d cycles expected fewer", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_legacy = 1'b0;
        req_desc = '0; req_offset = '0; req_len = '0;
        eng_ready = 1'b0; eng_done = 1'b0; eng_nack = 1'b0; eng_rdata = '0;
        rd_ready = 1'b0; wr_valid = 1'b0; wr_data = '0; got_n = 0; got_rn = 0;
        widx = 0; nack_at_g = -1; rbase = 0; hold_viol = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !eng_valid && !done && !rd_valid && !wr_ready, "R11", "reset state",
            int'({req_ready, eng_valid, done, rd_valid, wr_ready}), 16);

        // R1: address byte carries device bits 7:1 with direction in bit 0
        run("R1", 1, 0, 16'h00A5, 0, 1, -1);
        chk(got_ops[0] == 256 + 8'hA4, "R1", "write address byte", got_ops[0], 256 + 8'hA4);
        run("R1", 0, 0, 16'h015B, 16'h0033, 2, -1);
        chk(got_ops[2] == 256 + 8'h5B, "R1", "read address byte", got_ops[2], 256 + 8'h5B);
        // R2: oversize offset count rejected without bus activity
        run("R2", 0, 0, 16'h0350, 16'h1234, 3, -1);
        run("R2", 1, 0, 16'hFF50, 16'h1234, 3, -1);
        // R3: two offset bytes, low first, with idle gaps
        run("R3", 0, 0, 16'h02A0, 16'h3C5A, 2, -1);
        chk(acc_cyc[2] - done_cyc[1] >= GAP, "R3", "gap after offset 0", acc_cyc[2] - done_cyc[1], GAP);
        chk(acc_cyc[3] - done_cyc[2] >= GAP, "R3", "gap after offset 1", acc_cyc[3] - done_cyc[2], GAP);
        // R4 / R6: normal reads of one and several bytes
        run("R4", 0, 0, 16'h0190, 16'h0007, 1, -1);
        run("R6", 0, 0, 16'h0190, 16'h0007, 5, -1);
        // R5: legacy read and write
        run("R5", 0, 1, 16'h0000, 16'h00FF, 3, -1);
        run("R5", 1, 1, 16'h02A0, 16'h0041, 2, -1);
        // R7: NACK on address, on an offset byte and on the read address
        run("R7", 0, 0, 16'h02A0, 16'h1111, 2, 0);
        run("R7", 1, 0, 16'h02A0, 16'h1111, 2, 2);
        run("R7", 0, 0, 16'h01A0, 16'h1111, 2, 2);
        // R8: data NACK mid-write and a clean write
        run("R8", 1, 0, 16'h01A0, 16'h0022, 4, 3);
        run("R8", 1, 0, 16'h02A0, 16'h4422, 4, -1);
        // R9: zero length in both directions
        run("R9", 0, 0, 16'h02A0, 16'h4422, 0, -1);
        run("R9", 1, 1, 16'h0000, 16'h0010, 0, -1);

        for (int t = 0; t < 140; t++) begin
            bit wr, leg;
            int desc, ofs, len, nk;
            wr   = 1'($urandom);
            leg  = ($urandom % 4) == 0;
            desc = ((($urandom % 8 == 0) ? 3 : $urandom % 3) << 8) | ($urandom & 255);
            ofs  = $urandom & 16'hFFFF;
            len  = $urandom % 9;
            nk   = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
            run(leg ? "R5" : (wr ? "R8" : "R4"), wr, leg, desc, ofs, len, nk);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule